// File: doc/BRIEF.md
# Register-Subset Integer Execute Unit

This block decodes and executes a small integer subset of a 32-bit three-operand load/store machine. Each cycle it may accept one 32-bit instruction word. The word is in either the register format or the immediate format. The block reads up to two source registers from its own 32 x 32-bit register file. Register 0 of that file always reads as zero. The block then forms a result with its ALU and writes the result back to the destination register on the next rising clock edge.

For a load or store, the block only forms the byte address, which is the base register plus a sign-extended 16-bit offset. Nothing is written back for these instructions. Any opcode or function code outside the subset raises an illegal flag and causes no write. Instruction fetch, next-PC logic, data memory and traps are all handled outside this block.

The result, the destination index and the address are all combinational outputs for the instruction currently presented. The register file read ports are asynchronous. Because of this, an instruction sees the result of the instruction directly before it.

Top module: `rxuTop`

## Requirements
- R1: Reading register 0 always gives zero. A write aimed at register 0 still shows on the writeback outputs but leaves the register at zero.
- R2: In the register format (opcode 0x00), funct 0x20 produces rs + rt and funct 0x22 produces rs - rt. Both wrap modulo 2^32 and both are written to rd.
- R3: Register-format funct 0x2A writes 1 to rd when rs is less than rt as signed numbers, and writes 0 otherwise.
- R4: Opcode 0x08 writes rs plus the sign-extended immediate. Opcode 0x0A writes 1 when rs is signed-less-than the sign-extended immediate, and writes 0 otherwise.
- R5: Opcode 0x0C writes rs AND the zero-extended immediate. Opcode 0x0D writes rs OR the zero-extended immediate.
- R6: Opcode 0x0F writes the immediate into bits 31:16 with zeros in bits 15:0. This result followed by 0x0D on the same register builds any 32-bit constant.
- R7: The fields are opcode bits 31:26, rs bits 25:21, rt bits 20:16, rd bits 15:11 and immediate bits 15:0. The destination is rd in the register format and rt in the immediate format.
- R8: Opcodes 0x23 (load) and 0x2B (store) raise addrValid and set effAddr to rs plus the sign-extended immediate. They do not write back.
- R9: Any other opcode, or opcode 0x00 with a funct other than 0x20, 0x22 or 0x2A, raises illegalInstr. Such an instruction has no writeback, no address strobe and no register change.
- R10: A write commits on the rising clock edge and is seen by the next instruction. Reset clears every register to zero.
- R11: While instrValid is low, wbValid, addrValid and illegalInstr are all low and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; clears the register file |
| instrValid | input | 1 | The instruction word is valid this cycle |
| instrWord | input | 32 | Instruction to execute |
| wbValid | output | 1 | The current instruction writes a register |
| wbReg | output | 5 | Destination register index |
| wbData | output | 32 | Result to be written |
| addrValid | output | 1 | The current instruction is a load or store |
| effAddr | output | 32 | Base register plus sign-extended offset |
| illegalInstr | output | 1 | Opcode or funct outside the subset |

## Verification
The bench sweeps every source pair through add, subtract and set-less-than. The register values are chosen to include 0x7FFFFFFF, 0x80000000 and all-ones. With these values, an unsigned comparison flips the R3 result, and a carry wrongly kept would show in the wrapped sums.

The immediate sweep includes 0x7FFF, 0x8000 and 0xFFFF. At these values, swapping sign extension for zero extension would corrupt addi, slti and addresses, or would set the upper bits of andi and ori.

Every opcode and every register-format funct is presented. A decoder that lets an unlisted code write would be caught by a later read of that destination. So would a destination taken from the wrong field, and so would register 0 holding a written value.

// File: rtl/rxuPkg.sv
package rxuPkg;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_SLTI  = 6'h0A;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LUI   = 6'h0F;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_SLT,
    ALU_AND,
    ALU_OR,
    ALU_PASSB
  } aluOp_t;

  typedef enum logic [1:0] {
    IMM_SIGN,
    IMM_ZERO,
    IMM_UPPER
  } immKind_t;

  typedef struct packed {
    aluOp_t   aluOp;
    logic     useImm;
    immKind_t immKind;
    logic     regWrite;
    logic     destIsRt;
    logic     addrGen;
    logic     illegal;
  } ctrlStrobes_t;

endpackage

// File: rtl/rxuControl.sv
module rxuControl
  import rxuPkg::*;
(
  input  logic         instrValid,
  input  logic [5:0]   opcode,
  input  logic [5:0]   funct,
  output ctrlStrobes_t ctrl
);

  always_comb begin
    ctrl         = '0;
    ctrl.aluOp   = ALU_ADD;
    ctrl.immKind = IMM_SIGN;
    if (instrValid) begin
      case (opcode)
        OP_RTYPE: begin
          case (funct)
            FN_ADD: begin ctrl.aluOp = ALU_ADD; ctrl.regWrite = 1'b1; end
            FN_SUB: begin ctrl.aluOp = ALU_SUB; ctrl.regWrite = 1'b1; end
            FN_SLT: begin ctrl.aluOp = ALU_SLT; ctrl.regWrite = 1'b1; end
            default: ctrl.illegal = 1'b1;
          endcase
        end
        OP_ADDI: begin
          ctrl.aluOp = ALU_ADD; ctrl.useImm = 1'b1; ctrl.immKind = IMM_SIGN;
          ctrl.regWrite = 1'b1; ctrl.destIsRt = 1'b1;
        end
        OP_SLTI: begin
          ctrl.aluOp = ALU_SLT; ctrl.useImm = 1'b1; ctrl.immKind = IMM_SIGN;
          ctrl.regWrite = 1'b1; ctrl.destIsRt = 1'b1;
        end
        OP_ANDI: begin
          ctrl.aluOp = ALU_AND; ctrl.useImm = 1'b1; ctrl.immKind = IMM_ZERO;
          ctrl.regWrite = 1'b1; ctrl.destIsRt = 1'b1;
        end
        OP_ORI: begin
          ctrl.aluOp = ALU_OR; ctrl.useImm = 1'b1; ctrl.immKind = IMM_ZERO;
          ctrl.regWrite = 1'b1; ctrl.destIsRt = 1'b1;
        end
        OP_LUI: begin
          ctrl.aluOp = ALU_PASSB; ctrl.useImm = 1'b1; ctrl.immKind = IMM_UPPER;
          ctrl.regWrite = 1'b1; ctrl.destIsRt = 1'b1;
        end
        OP_LOAD, OP_STORE: begin
          ctrl.aluOp = ALU_ADD; ctrl.useImm = 1'b1; ctrl.immKind = IMM_SIGN;
          ctrl.addrGen = 1'b1;
        end
        default: ctrl.illegal = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/rxuRegFile.sv
module rxuRegFile #(
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 32,
  parameter int RD_PORTS  = 2,
  localparam int IDX_W    = $clog2(REG_COUNT)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [RD_PORTS-1:0][IDX_W-1:0]   rdIdx,
  output logic [RD_PORTS-1:0][DATA_W-1:0]  rdData,
  input  logic                             wrEn,
  input  logic [IDX_W-1:0]                 wrIdx,
  input  logic [DATA_W-1:0]                wrData
);

  logic [DATA_W-1:0] storeArr [REG_COUNT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) storeArr[i] <= '0;
    end else if (wrEn && (wrIdx != '0)) begin
      storeArr[wrIdx] <= wrData;
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : gReadPort
    assign rdData[p] = (rdIdx[p] == '0) ? '0 : storeArr[rdIdx[p]];
  end

endmodule

// File: rtl/rxuDatapath.sv
module rxuDatapath
  import rxuPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 32,
  localparam int IDX_W    = $clog2(REG_COUNT),
  localparam int IMM_W    = 16,
  localparam int FILL_W   = DATA_W - IMM_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [25:0]        instrLow,
  input  ctrlStrobes_t       ctrl,
  output logic               wbValid,
  output logic [IDX_W-1:0]   wbReg,
  output logic [DATA_W-1:0]  wbData,
  output logic               addrValid,
  output logic [DATA_W-1:0]  effAddr
);

  logic [IDX_W-1:0]          rsIdx, rtIdx, rdIdx;
  logic [IMM_W-1:0]          imm;
  logic [1:0][IDX_W-1:0]     readIdx;
  logic [1:0][DATA_W-1:0]    readData;
  logic [DATA_W-1:0]         immExt, opA, opB, sum, diff, aluResult;
  logic                      lessSigned;

  assign rsIdx = instrLow[25:21];
  assign rtIdx = instrLow[20:16];
  assign rdIdx = instrLow[15:11];
  assign imm   = instrLow[15:0];

  assign readIdx[0] = rsIdx;
  assign readIdx[1] = rtIdx;

  rxuRegFile #(
    .DATA_W   (DATA_W),
    .REG_COUNT(REG_COUNT),
    .RD_PORTS (2)
  ) uRegFile (
    .clk   (clk),
    .rstN  (rstN),
    .rdIdx (readIdx),
    .rdData(readData),
    .wrEn  (ctrl.regWrite),
    .wrIdx (wbReg),
    .wrData(aluResult)
  );

  always_comb begin
    case (ctrl.immKind)
      IMM_ZERO:  immExt = {{FILL_W{1'b0}}, imm};
      IMM_UPPER: immExt = {imm, {FILL_W{1'b0}}};
      default:   immExt = {{FILL_W{imm[IMM_W-1]}}, imm};
    endcase
  end

  assign opA        = readData[0];
  assign opB        = ctrl.useImm ? immExt : readData[1];
  assign sum        = opA + opB;
  assign diff       = opA - opB;
  assign lessSigned = $signed(opA) < $signed(opB);

  always_comb begin
    case (ctrl.aluOp)
      ALU_SUB:   aluResult = diff;
      ALU_SLT:   aluResult = {{(DATA_W-1){1'b0}}, lessSigned};
      ALU_AND:   aluResult = opA & opB;
      ALU_OR:    aluResult = opA | opB;
      ALU_PASSB: aluResult = opB;
      default:   aluResult = sum;
    endcase
  end

  assign wbValid   = ctrl.regWrite;
  assign wbReg     = ctrl.destIsRt ? rtIdx : rdIdx;
  assign wbData    = aluResult;
  assign addrValid = ctrl.addrGen;
  assign effAddr   = sum;

endmodule

// File: rtl/rxuTop.sv
module rxuTop
  import rxuPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 32,
  localparam int IDX_W    = $clog2(REG_COUNT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [31:0]        instrWord,
  output logic               wbValid,
  output logic [IDX_W-1:0]   wbReg,
  output logic [DATA_W-1:0]  wbData,
  output logic               addrValid,
  output logic [DATA_W-1:0]  effAddr,
  output logic               illegalInstr
);

  ctrlStrobes_t ctrl;

  rxuControl uControl (
    .instrValid(instrValid),
    .opcode    (instrWord[31:26]),
    .funct     (instrWord[5:0]),
    .ctrl      (ctrl)
  );

  rxuDatapath #(
    .DATA_W   (DATA_W),
    .REG_COUNT(REG_COUNT)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .instrLow (instrWord[25:0]),
    .ctrl     (ctrl),
    .wbValid  (wbValid),
    .wbReg    (wbReg),
    .wbData   (wbData),
    .addrValid(addrValid),
    .effAddr  (effAddr)
  );

  assign illegalInstr = ctrl.illegal;

endmodule

// File: rtl/rxuChecker.sv
module rxuChecker (
  input logic        clk,
  input logic        rstN,
  input logic        instrValid,
  input logic [31:0] instrWord,
  input logic        wbValid,
  input logic [4:0]  wbReg,
  input logic [31:0] wbData,
  input logic        addrValid,
  input logic [31:0] effAddr,
  input logic        illegalInstr
);

  logic [5:0]  opc;
  logic [5:0]  fn;
  logic [4:0]  rsF;
  logic [31:0] offs;

  assign opc  = instrWord[31:26];
  assign fn   = instrWord[5:0];
  assign rsF  = instrWord[25:21];
  assign offs = {{16{instrWord[15]}}, instrWord[15:0]};

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    illegalInstr |-> (!wbValid && !addrValid)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |-> (!wbValid && !addrValid && !illegalInstr)); // R11

  AST_MEM_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> !wbValid); // R8

  AST_SLT_BOOL: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && ((opc == 6'h00 && fn == 6'h2A) || opc == 6'h0A)) |-> (wbData[31:1] == 31'd0)); // R3

  AST_LUI_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && opc == 6'h0F) |-> (wbData[15:0] == 16'd0 && wbData[31:16] == instrWord[15:0])); // R6

  AST_DEST_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (wbReg == ((opc == 6'h00) ? instrWord[15:11] : instrWord[20:16]))); // R7

  AST_ZERO_BASE: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && rsF == 5'd0) |-> (effAddr == offs)); // R1

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wbValid) && $past(wbReg) != 5'd0 && addrValid && rsF == $past(wbReg))
      |-> (effAddr == $past(wbData) + offs)); // R10

endmodule

bind rxuTop rxuChecker uChk (.*);

// File: tb/tb_rxuTop.sv
module tb_rxuTop;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic        wbValid;
  logic [4:0]  wbReg;
  logic [31:0] wbData;
  logic        addrValid;
  logic [31:0] effAddr;
  logic        illegalInstr;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [32];

  always #2 clk = ~clk;

  rxuTop dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .wbValid(wbValid), .wbReg(wbReg), .wbData(wbData),
    .addrValid(addrValid), .effAddr(effAddr), .illegalInstr(illegalInstr)
  );

  function automatic logic [31:0] rEnc(input logic [5:0] fn, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [4:0] rd);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] iEnc(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  // Expected values follow the requirements; R7 field positions used throughout.
  task automatic runInstr(input logic [31:0] iw, input string tagOverride = "");
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, expReg;
    logic [15:0] imm;
    logic [31:0] a, b, sx, zx, expData;
    logic        expWb, expAddr, expIll, ok;
    string       tag;
    op = iw[31:26]; fn = iw[5:0]; rs = iw[25:21]; rt = iw[20:16]; rd = iw[15:11];
    imm = iw[15:0];
    a = model[rs]; b = model[rt];
    sx = {{16{imm[15]}}, imm}; zx = {16'd0, imm};
    expWb = 1'b0; expAddr = 1'b0; expIll = 1'b0; expData = '0; expReg = rt; tag = "R9";
    case (op)
      6'h00: begin
        expReg = rd;
        case (fn)
          6'h20: begin expWb = 1; expData = a + b; tag = "R2"; end
          6'h22: begin expWb = 1; expData = a - b; tag = "R2"; end
          6'h2A: begin expWb = 1; expData = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R3"; end
          default: expIll = 1;
        endcase
      end
      6'h08: begin expWb = 1; expData = a + sx; tag = "R4"; end
      6'h0A: begin expWb = 1; expData = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0; tag = "R4"; end
      6'h0C: begin expWb = 1; expData = a & zx; tag = "R5"; end
      6'h0D: begin expWb = 1; expData = a | zx; tag = "R5"; end
      6'h0F: begin expWb = 1; expData = {imm, 16'd0}; tag = "R6"; end
      6'h23, 6'h2B: begin expAddr = 1; tag = "R8"; end
      default: expIll = 1;
    endcase
    if (expWb && expReg == 5'd0) tag = "R1";
    if (tagOverride != "") tag = tagOverride;
    @(negedge clk);
    instrValid = 1'b1;
    instrWord  = iw;
    #1;
    ok = (illegalInstr === expIll) && (wbValid === expWb) && (addrValid === expAddr);
    if (expWb)   ok = ok && (wbReg === expReg) && (wbData === expData);
    if (expAddr) ok = ok && (effAddr === a + sx);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s instr=%h actual ill=%b wb=%b reg=%0d data=%h addr=%b ea=%h expected ill=%b wb=%b reg=%0d data=%h addr=%b ea=%h",
               tag, iw, illegalInstr, wbValid, wbReg, wbData, addrValid, effAddr,
               expIll, expWb, expReg, expData, expAddr, a + sx);
    end
    if (expWb && expReg != 5'd0) model[expReg] = expData;
  endtask

  task automatic probe(input logic [4:0] idx, input string tag);
    runInstr(iEnc(6'h23, idx, 5'd0, 16'h0000), tag);
  endtask

  function automatic logic [31:0] seedVal(input int k);
    case (k)
      1: return 32'h7FFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'hFFFF_FFFF;
      4: return 32'h0000_0001;
      5: return 32'h0000_0000;
      default: return (k * 32'h9E37_79B1) ^ (k << 7);
    endcase
  endfunction

  bit finished = 1'b0;

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 32; k++) model[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R10: reset clears every register
    for (int k = 0; k < 32; k++) probe(k[4:0], "R10");

    // R6 then R5: build constants with upper-half load followed by or-immediate
    for (int k = 1; k < 32; k++) begin
      logic [31:0] v;
      v = seedVal(k);
      runInstr(iEnc(6'h0F, 5'd0, k[4:0], v[31:16]));
      runInstr(iEnc(6'h0D, k[4:0], k[4:0], v[15:0]));
    end
    for (int k = 1; k < 32; k++) probe(k[4:0], "R6");

    // R1: writes to register 0 are dropped
    runInstr(iEnc(6'h08, 5'd3, 5'd0, 16'h0007));
    runInstr(iEnc(6'h0F, 5'd0, 5'd0, 16'hABCD));
    runInstr(rEnc(6'h20, 5'd1, 5'd3, 5'd0));
    probe(5'd0, "R1");

    // R2, R3, R7: all source pairs, destinations rotating through every index
    for (int s = 0; s < 32; s++) begin
      for (int t = 0; t < 32; t++) begin
        runInstr(rEnc(6'h2A, s[4:0], t[4:0], 5'((s * 3 + t) % 32)));
        runInstr(rEnc(6'h20, s[4:0], t[4:0], 5'((s + t + 7) % 32)));
        runInstr(rEnc(6'h22, s[4:0], t[4:0], 5'((s + 2 * t) % 32)));
      end
      if (s % 4 == 3) begin
        for (int k = 1; k < 6; k++) begin
          logic [31:0] v;
          v = seedVal(k);
          runInstr(iEnc(6'h0F, 5'd0, k[4:0], v[31:16]));
          runInstr(iEnc(6'h0D, k[4:0], k[4:0], v[15:0]));
        end
      end
    end

    // R4, R5, R6, R8: immediate sweep including sign-boundary values
    for (int i = 0; i < 72; i++) begin
      logic [15:0] imm;
      logic [4:0]  rs, rt;
      case (i)
        0: imm = 16'h0000;
        1: imm = 16'h0001;
        2: imm = 16'h7FFF;
        3: imm = 16'h8000;
        4: imm = 16'hFFFF;
        default: imm = 16'(i * 16'h0411) ^ 16'(i << 10);
      endcase
      rs = 5'(i % 32);
      rt = 5'((i * 7 + 1) % 32);
      runInstr(iEnc(6'h0A, rs, rt, imm));
      runInstr(iEnc(6'h08, rs, rt, imm));
      runInstr(iEnc(6'h0C, rs, rt, imm));
      runInstr(iEnc(6'h0D, rs, rt, imm));
      runInstr(iEnc(6'h23, rs, rt, imm));
      runInstr(iEnc(6'h2B, rs, rt, imm));
      runInstr(iEnc(6'h0F, rs, rt, imm));
      probe(rt, "R8");
    end

    // R9: every opcode and every register-format funct; destination read back after
    for (int op = 0; op < 64; op++) begin
      runInstr(iEnc(6'(op), 5'd2, 5'd9, 16'h5A20 | 16'(op)));
      probe(5'd9, "R9");
    end
    for (int fn = 0; fn < 64; fn++) begin
      runInstr(rEnc(6'(fn), 5'd1, 5'd2, 5'd10));
      probe(5'd10, "R9");
    end

    // R11: an invalid cycle has no effect
    begin
      logic ok;
      @(negedge clk);
      instrValid = 1'b0;
      instrWord  = iEnc(6'h08, 5'd0, 5'd11, 16'h0055);
      #1;
      ok = !wbValid && !addrValid && !illegalInstr;
      checks++;
      if (!ok) begin
        errors++;
        $display("FAIL R11 actual wb=%b addr=%b ill=%b expected 0 0 0", wbValid, addrValid, illegalInstr);
      end
      @(negedge clk);
      instrWord = 32'hFC00_0000;
      #1;
      ok = !wbValid && !addrValid && !illegalInstr;
      checks++;
      if (!ok) begin
        errors++;
        $display("FAIL R11 actual wb=%b addr=%b ill=%b expected 0 0 0", wbValid, addrValid, illegalInstr);
      end
      probe(5'd11, "R11");
    end

    @(negedge clk);
    instrValid = 1'b0;
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule